// File: doc/BRIEF.md
# Dual-Mode Four-Channel Arbiter

This block decides which of four requesting channels may use one shared resource, for example a shared datapath or a pool of execution units. It holds a single one-hot grant. The grant stays with its holder until the holder signals completion. A new decision is made only while the resource is free. That means no grant is held, or the holder raises `done` in that cycle.

Two programmable loss limits select the policy, one for channel 3 and one for channel 4. When both limits are zero, the block hands out grants in rotating order. When either limit is nonzero, it uses a fixed ranking led by channel 1. In that ranking, channel 3 or channel 4 moves ahead of channel 2 once it has lost the programmed number of rounds in a row. This prevents those two channels from being starved.

Channels 1 to 4 map to bit 0 to bit 3 of `req` and `gnt`.

Top module: `chan_arb4`

## Requirements
- R1: After reset, `gnt` is 4'b0000 and both loss counters are zero. The rotating pointer rests on channel 4, so the first rotating search starts at channel 1.
- R2: Rotating mode applies when `lim3` and `lim4` are both zero. Otherwise the weighted mode applies.
- R3: In rotating mode, the search starts at the channel after the last granted one and continues in the order 1,2,3,4,1. It skips idle channels and grants the first requester it finds. The pointer moves to each new winner in both modes.
- R4: A decision happens only in a cycle where `gnt` is zero or `done` is 1. The decision appears on `gnt` after the next clock edge. While `gnt` is nonzero and `done` is 0, `gnt` keeps its value.
- R5: In a decision cycle with `req` equal to zero, `gnt` becomes zero. The loss counters and the pointer do not change.
- R6: In weighted mode with no promotion, the ranking is 1,2,3,4. Channel 1 wins whenever it requests.
- R7: In weighted mode, a loss counter adds one in each round where its channel requests and another channel wins. It saturates at all ones and clears when its channel wins. Every rotating-mode round with a winner clears both counters.
- R8: When the channel 3 counter is at or above a nonzero `lim3`, channel 3 is promoted, and the ranking becomes 1,3,2,4.
- R9: When the channel 4 counter is at or above a nonzero `lim4`, channel 4 is promoted, and the ranking becomes 1,4,2,3.
- R10: When both channels are promoted in the same round, the ranking becomes 1,3,4,2.
- R11: `gnt` never has more than one bit set. A grant only goes to a channel that was requesting in the decision cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request lines, bit 0 is channel 1 |
| done | input | 1 | Current holder releases the resource |
| lim3 | input | CNT_W | Loss limit for channel 3 (0 disables promotion) |
| lim4 | input | CNT_W | Loss limit for channel 4 (0 disables promotion) |
| gnt | output | 4 | Registered one-hot grant |

## Verification
The properties hold on every cycle for the following behaviours:
- the grant is one-hot or zero and only goes to a requester;
- the grant stays stable between releases;
- an empty decision clears the grant without touching the counters;
- channel 1 always wins in weighted mode;
- rotating-mode rounds clear the counters.

Only the bench scenarios can show the actual rotation sequence, the build-up of losses toward each limit, and the three promoted rankings. The bench compares every cycle of a sweep over sixteen limit pairs against an arithmetic model of both modes.

// File: rtl/arb4_pkg.sv
package arb4_pkg;
    localparam int NCH   = 4;
    localparam int PTR_W = $clog2(NCH);
    localparam int NPROM = 2;   // channels 3 and 4 carry loss counters

    function automatic logic [PTR_W-1:0] oh_to_idx(input logic [NCH-1:0] oh);
        logic [PTR_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (oh[i]) idx = PTR_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/arb4_rr_pick.sv
module arb4_rr_pick
    import arb4_pkg::*;
(
    input  logic [NCH-1:0]   req,
    input  logic [PTR_W-1:0] last,
    output logic [NCH-1:0]   pick
);
    logic [PTR_W-1:0] idx;
    logic             found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= NCH; k++) begin
            idx = last + PTR_W'(k);
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb4_wt_pick.sv
module arb4_wt_pick
    import arb4_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic           prom3,
    input  logic           prom4,
    output logic [NCH-1:0] pick
);
    logic [NCH-1:0][PTR_W-1:0] rank;
    logic                      found;

    always_comb begin
        rank[0] = PTR_W'(0);
        unique case ({prom4, prom3})
            2'b01: begin rank[1] = PTR_W'(2); rank[2] = PTR_W'(1); rank[3] = PTR_W'(3); end
            2'b10: begin rank[1] = PTR_W'(3); rank[2] = PTR_W'(1); rank[3] = PTR_W'(2); end
            2'b11: begin rank[1] = PTR_W'(2); rank[2] = PTR_W'(3); rank[3] = PTR_W'(1); end
            default: begin rank[1] = PTR_W'(1); rank[2] = PTR_W'(2); rank[3] = PTR_W'(3); end
        endcase
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            if (!found && req[rank[k]]) begin
                pick[rank[k]] = 1'b1;
                found         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/chan_arb4.sv
module chan_arb4
    import arb4_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       req,
    input  logic             done,
    input  logic [CNT_W-1:0] lim3,
    input  logic [CNT_W-1:0] lim4,
    output logic [3:0]       gnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NCH-1:0]              gnt;
        logic [PTR_W-1:0]            ptr;
        logic [NPROM-1:0][CNT_W-1:0] loss;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NPROM-1:0][CNT_W-1:0] lim_v;
    logic [NPROM-1:0]            prom;
    logic [NCH-1:0]              rr_pick, wt_pick, pick;
    logic                        idle, rr_mode;

    assign lim_v = {lim4, lim3};

    for (genvar i = 0; i < NPROM; i++) begin : g_prom
        assign prom[i] = (lim_v[i] != '0) && (st_q.loss[i] >= lim_v[i]);
    end

    arb4_rr_pick u_rr (
        .req  (req),
        .last (st_q.ptr),
        .pick (rr_pick)
    );

    arb4_wt_pick u_wt (
        .req   (req),
        .prom3 (prom[0]),
        .prom4 (prom[1]),
        .pick  (wt_pick)
    );

    always_comb begin
        st_d    = st_q;
        idle    = (st_q.gnt == '0) || done;
        rr_mode = (lim3 == '0) && (lim4 == '0);
        pick    = rr_mode ? rr_pick : wt_pick;
        if (idle) begin
            st_d.gnt = pick;
            if (pick != '0) begin
                st_d.ptr = oh_to_idx(pick);
                for (int i = 0; i < NPROM; i++) begin
                    if (rr_mode || pick[NCH-NPROM+i]) begin
                        st_d.loss[i] = '0;
                    end else if (req[NCH-NPROM+i] && st_q.loss[i] != CNT_MAX) begin
                        st_d.loss[i] = st_q.loss[i] + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt  <= '0;
            st_q.ptr  <= PTR_W'(NCH-1);
            st_q.loss <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;
endmodule

// File: rtl/chan_arb4_chk.sv
module chan_arb4_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       req,
    input logic             done,
    input logic [CNT_W-1:0] lim3,
    input logic [CNT_W-1:0] lim4,
    input logic [3:0]       gnt,
    input logic [CNT_W-1:0] loss3,
    input logic [CNT_W-1:0] loss4
);
    logic free_now, weighted;
    assign free_now = (gnt == 4'b0000) || done;
    assign weighted = (lim3 != '0) || (lim4 != '0);

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_to_requester_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && req != 4'b0000) |=> (gnt != 4'b0000) && ((gnt & $past(req)) == gnt));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != 4'b0000 && !done) |=> $stable(gnt));

    p_empty_round_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && req == 4'b0000) |=> (gnt == 4'b0000) && $stable(loss3) && $stable(loss4));

    p_ch1_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && weighted && req[0]) |=> (gnt == 4'b0001));

    p_rr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && !weighted && req != 4'b0000) |=> (loss3 == '0) && (loss4 == '0));
endmodule

bind chan_arb4 chan_arb4_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .done  (done),
    .lim3  (lim3),
    .lim4  (lim4),
    .gnt   (gnt),
    .loss3 (st_q.loss[0]),
    .loss4 (st_q.loss[1])
);

// File: tb/sim_chan_arb4.sv
`timescale 1ns/1ps
module sim_chan_arb4;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    req = '0;
    logic          done = 1'b0;
    logic [CW-1:0] lim3 = '0;
    logic [CW-1:0] lim4 = '0;
    logic [3:0]    gnt;

    int n_vec = 0;
    int n_bad = 0;
    bit ended = 0;

    // model state
    logic [3:0] m_gnt;
    int         m_ptr, m_c3, m_c4;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    chan_arb4 #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done),
        .lim3(lim3), .lim4(lim4), .gnt(gnt)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit   free_now;
        int   win;
        int   rank[4];
        bit   e3, e4;
        free_now = (m_gnt == 4'b0000) || done;
        if (!free_now) return;
        if (req == 4'b0000) begin
            m_gnt = 4'b0000;
            return;
        end
        win = -1;
        if (lim3 == 0 && lim4 == 0) begin
            for (int k = 1; k <= 4; k++)
                if (win < 0 && req[(m_ptr + k) % 4]) win = (m_ptr + k) % 4;
            m_c3 = 0;
            m_c4 = 0;
        end else begin
            e3 = (lim3 != 0) && (m_c3 >= int'(lim3));
            e4 = (lim4 != 0) && (m_c4 >= int'(lim4));
            rank[0] = 0;
            if (e3 && e4)  begin rank[1] = 2; rank[2] = 3; rank[3] = 1; end
            else if (e3)   begin rank[1] = 2; rank[2] = 1; rank[3] = 3; end
            else if (e4)   begin rank[1] = 3; rank[2] = 1; rank[3] = 2; end
            else           begin rank[1] = 1; rank[2] = 2; rank[3] = 3; end
            for (int k = 0; k < 4; k++)
                if (win < 0 && req[rank[k]]) win = rank[k];
            if (win == 2) m_c3 = 0; else if (req[2] && m_c3 < CMAX) m_c3++;
            if (win == 3) m_c4 = 0; else if (req[3] && m_c4 < CMAX) m_c4++;
        end
        m_ptr = win;
        m_gnt = 4'b0001 << win;
    endtask

    task automatic do_reset(input logic [CW-1:0] a, input logic [CW-1:0] b);
        rst_n = 1'b0; req = '0; done = 1'b0; lim3 = a; lim4 = b;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        m_gnt = '0; m_ptr = 3; m_c3 = 0; m_c4 = 0;
    endtask

    // apply inputs, clock once, compare against model and optional literal
    task automatic step(input logic [3:0] r, input logic d, input string tag);
        req = r; done = d;
        model_step();
        @(posedge clk); #1;
        chk(tag, gnt, m_gnt);
    endtask

    task automatic expect_lit(input string tag, input logic [3:0] exp);
        chk(tag, gnt, exp);
    endtask

    initial begin
        do_reset(0, 0);
        expect_lit("R1 reset", 4'b0000);

        // R1/R3: rotation from channel 1 with all requesting
        step(4'b1111, 1, "R3"); expect_lit("R1 first rotating grant", 4'b0001);
        step(4'b1111, 1, "R3"); expect_lit("R3", 4'b0010);
        step(4'b1111, 1, "R3"); expect_lit("R3", 4'b0100);
        step(4'b1111, 1, "R3"); expect_lit("R3", 4'b1000);
        step(4'b1111, 1, "R3"); expect_lit("R3 wrap", 4'b0001);
        step(4'b1010, 1, "R3"); expect_lit("R3 skip", 4'b0010);
        step(4'b1010, 1, "R3"); expect_lit("R3 skip", 4'b1000);
        // R4: held without done
        step(4'b1111, 0, "R4"); expect_lit("R4 hold", 4'b1000);
        step(4'b0001, 0, "R4"); expect_lit("R4 hold", 4'b1000);
        step(4'b0001, 1, "R4"); expect_lit("R4 release", 4'b0001);
        // R5: no requests
        step(4'b0000, 1, "R5"); expect_lit("R5 empty", 4'b0000);
        step(4'b0010, 0, "R5"); expect_lit("R5 pointer kept", 4'b0010);

        // R2/R6: weighted base order
        do_reset(5, 0);
        step(4'b1111, 1, "R6"); expect_lit("R2 weighted ch1", 4'b0001);
        step(4'b1111, 1, "R6"); expect_lit("R6 ch1 again", 4'b0001);
        step(4'b1110, 1, "R6"); expect_lit("R6 ch2", 4'b0010);
        step(4'b1100, 1, "R6"); expect_lit("R6 ch3", 4'b0100);

        // R8/R7: channel 3 promotion with lim3=2
        do_reset(2, 0);
        step(4'b0110, 1, "R8"); expect_lit("R8 loss1", 4'b0010);
        step(4'b0110, 1, "R8"); expect_lit("R8 loss2", 4'b0010);
        step(4'b0110, 1, "R8"); expect_lit("R8 promoted", 4'b0100);
        step(4'b0110, 1, "R7"); expect_lit("R7 cleared after win", 4'b0010);

        // R9: channel 4 promotion with lim4=1
        do_reset(0, 1);
        step(4'b1010, 1, "R9"); expect_lit("R9", 4'b0010);
        step(4'b1010, 1, "R9"); expect_lit("R9 promoted", 4'b1000);
        step(4'b1010, 1, "R9"); expect_lit("R9", 4'b0010);

        // R10: both promoted together
        do_reset(1, 1);
        step(4'b1110, 1, "R10"); expect_lit("R10", 4'b0010);
        step(4'b1110, 1, "R10"); expect_lit("R10 ch3 before ch4", 4'b0100);
        step(4'b1110, 1, "R10"); expect_lit("R10 ch4 before ch2", 4'b1000);
        step(4'b1110, 1, "R10"); expect_lit("R10", 4'b0100);

        // sweep over all limit pairs 0..3, pseudo-random traffic
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset(CW'(a), CW'(b));
                for (int n = 0; n < 150; n++) begin
                    logic [3:0] pg;
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    pg = gnt;
                    step(lfsr[3:0], lfsr[7] | lfsr[9], (a == 0 && b == 0) ? "R3 sweep" : "R7 sweep");
                    n_vec++;
                    if (!$onehot0(gnt) || ((gnt & req) != gnt && gnt != pg)) begin
                        n_bad++;
                        $display("FAIL R11: gnt=%b expected one-hot subset of %b", gnt, req);
                    end
                end
            end
        end

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule